// File: doc/BRIEF.md
# Multiplier with Scaled Product Register

This block is the multiply stage of a fixed-point datapath. A 16-bit temporary operand register is multiplied by a 16-bit data word, by an immediate, or the data word is squared. The full 32-bit result is captured in a product register one cycle after a multiply strobe. The multiply can be signed or unsigned. Unsigned mode lets software assemble products of operands wider than 16 bits from partial products. The two square modes differ only in the add or subtract directive they hand to the accumulator stage downstream. That stage lies outside this block.

The product register is never read raw. Both 16-bit read ports show the register after a scaling shifter, and a 2-bit product-mode input selects the shift. The register has no direct write path for its low half. Software clears it with a multiply by immediate 0. To restore a saved value, software loads the saved low half into the temporary register, multiplies by immediate 1, and then writes the high half through a direct high-half load.

Top module: `prod_mul_unit`

## Requirements
- R1: After reset the product register, the temporary register and `acc_cmd_o` are all zero, so both read ports return 0.
- R2: `op_mode_i` = 3'b000 with `op_valid_i` high loads the signed product of the temporary register and `data_i`. The product register shows it from the next rising clock edge.
- R3: `op_mode_i` = 3'b001 loads the unsigned product of the temporary register and `data_i`.
- R4: `op_mode_i` = 3'b010 and 3'b011 load the signed square of `data_i`. For the one cycle after the strobe, `acc_cmd_o` is 2'b01 for 3'b010 and 2'b10 for 3'b011. In every other cycle `acc_cmd_o` is 2'b00.
- R5: `op_mode_i` = 3'b100 loads the signed product of the temporary register and `imm_i`. With `imm_i` = 0 this clears the product register.
- R6: A strobe with `op_mode_i` of 3'b101, 3'b110 or 3'b111 leaves the product register unchanged and gives `acc_cmd_o` = 2'b00.
- R7: `pm_i` selects the readout scaling. 2'b00 applies no shift, 2'b01 a left shift by 1, 2'b10 a left shift by 4, and 2'b11 an arithmetic right shift by 6. Bits shifted in from the right are zero.
- R8: `prod_hi_o` is bits 31:16 and `prod_lo_o` is bits 15:0 of the same scaled value. Both halves are combinational from the registered product.
- R9: `hi_load_i` replaces product bits 31:16 with `hi_data_i` at the next edge and leaves bits 15:0 unchanged.
- R10: When a valid multiply and `hi_load_i` fall in the same cycle, bits 15:0 come from the new product and bits 31:16 come from `hi_data_i`.
- R11: `tmp_we_i` loads `data_i` into the temporary register. A multiply strobe in the same cycle uses the previous temporary value.
- R12: Three steps restore a saved 32-bit value exactly, as read with `pm_i` = 2'b00. First the low half is loaded into the temporary register. Then a multiply by immediate 1 follows. Then the high half is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmp_we_i | input | 1 | Load `data_i` into the temporary register |
| op_valid_i | input | 1 | Multiply strobe |
| op_mode_i | input | 3 | Multiply mode |
| data_i | input | 16 | Data word operand |
| imm_i | input | 16 | Immediate operand |
| hi_load_i | input | 1 | Direct high-half load strobe |
| hi_data_i | input | 16 | High-half load value |
| pm_i | input | 2 | Product scaling mode |
| prod_hi_o | output | 16 | Scaled product, upper half |
| prod_lo_o | output | 16 | Scaled product, lower half |
| acc_cmd_o | output | 2 | Directive to the accumulator stage (01 add, 10 subtract) |

## Verification
Two functions can land in the same cycle: a multiply strobe and a direct high-half load. A write to the temporary register can also coincide with a multiply that reads it. The bench drives both pairs in a single cycle. For the first pair it expects the high half from the load and the low half from the product. For the second pair it judges the product against the old temporary value, and then confirms with a following multiply that the new value was stored.

// File: rtl/prod_mul_pkg.sv
package prod_mul_pkg;
  typedef enum logic [2:0] {
    MODE_MUL_S   = 3'b000,
    MODE_MUL_U   = 3'b001,
    MODE_SQR_ADD = 3'b010,
    MODE_SQR_SUB = 3'b011,
    MODE_MUL_IMM = 3'b100
  } mode_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_ADD  = 2'b01,
    ACC_SUB  = 2'b10
  } acc_cmd_e;

  typedef enum logic [1:0] {
    PM_NONE  = 2'b00,
    PM_SHL_A = 2'b01,
    PM_SHL_B = 2'b10,
    PM_SHR_C = 2'b11
  } pm_e;
endpackage

// File: rtl/prod_operand_sel.sv
module prod_operand_sel
  import prod_mul_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [2:0]        mode_i,
  input  logic [DATA_W-1:0] tmp_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic              known_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic              signed_o,
  output logic [1:0]        acc_o
);
  always_comb begin
    known_o  = 1'b1;
    a_o      = tmp_i;
    b_o      = data_i;
    signed_o = 1'b1;
    acc_o    = ACC_NONE;
    unique case (mode_i)
      MODE_MUL_S: ;
      MODE_MUL_U: signed_o = 1'b0;
      MODE_SQR_ADD: begin
        a_o   = data_i;
        acc_o = ACC_ADD;
      end
      MODE_SQR_SUB: begin
        a_o   = data_i;
        acc_o = ACC_SUB;
      end
      MODE_MUL_IMM: b_o = imm_i;
      default: known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/prod_mult.sv
module prod_mult #(
  parameter int DATA_W = 16,
  localparam int PROD_W = 2 * DATA_W,
  localparam int EXT_W  = DATA_W + 1,
  localparam int FULL_W = 2 * EXT_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              signed_i,
  output logic [PROD_W-1:0] prod_o
);
  logic [EXT_W-1:0]  a_x, b_x;
  logic [FULL_W-1:0] full;

  // one extra bit makes a single signed array serve both signednesses
  assign a_x  = {signed_i & a_i[DATA_W-1], a_i};
  assign b_x  = {signed_i & b_i[DATA_W-1], b_i};
  assign full = $signed({{EXT_W{a_x[EXT_W-1]}}, a_x}) *
                $signed({{EXT_W{b_x[EXT_W-1]}}, b_x});
  assign prod_o = full[PROD_W-1:0];
endmodule

// File: rtl/prod_scaler.sv
module prod_scaler
  import prod_mul_pkg::*;
#(
  parameter int PROD_W = 32,
  parameter int SHL_A  = 1,
  parameter int SHL_B  = 4,
  parameter int SHR_C  = 6
) (
  input  logic [1:0]        pm_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic [PROD_W-1:0] scaled_o
);
  logic signed [PROD_W-1:0] prod_s;
  assign prod_s = $signed(prod_i);

  always_comb begin
    unique case (pm_i)
      PM_SHL_A: scaled_o = prod_i << SHL_A;
      PM_SHL_B: scaled_o = prod_i << SHL_B;
      PM_SHR_C: scaled_o = $unsigned(prod_s >>> SHR_C);
      default:  scaled_o = prod_i;
    endcase
  end
endmodule

// File: rtl/prod_mul_unit.sv
module prod_mul_unit
  import prod_mul_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SHL_A  = 1,
  parameter int SHL_B  = 4,
  parameter int SHR_C  = 6,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmp_we_i,
  input  logic              op_valid_i,
  input  logic [2:0]        op_mode_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              hi_load_i,
  input  logic [DATA_W-1:0] hi_data_i,
  input  logic [1:0]        pm_i,
  output logic [DATA_W-1:0] prod_hi_o,
  output logic [DATA_W-1:0] prod_lo_o,
  output logic [1:0]        acc_cmd_o
);
  logic [DATA_W-1:0] tmp_q;
  logic [PROD_W-1:0] prod_q, prod_d, mul_res, scaled;
  logic [DATA_W-1:0] op_a, op_b;
  logic              op_known, op_signed;
  logic [1:0]        op_acc, acc_q;
  logic              op_fire;

  prod_operand_sel #(.DATA_W(DATA_W)) u_sel (
    .mode_i  (op_mode_i),
    .tmp_i   (tmp_q),
    .data_i  (data_i),
    .imm_i   (imm_i),
    .known_o (op_known),
    .a_o     (op_a),
    .b_o     (op_b),
    .signed_o(op_signed),
    .acc_o   (op_acc)
  );

  prod_mult #(.DATA_W(DATA_W)) u_mult (
    .a_i     (op_a),
    .b_i     (op_b),
    .signed_i(op_signed),
    .prod_o  (mul_res)
  );

  prod_scaler #(
    .PROD_W(PROD_W), .SHL_A(SHL_A), .SHL_B(SHL_B), .SHR_C(SHR_C)
  ) u_scale (
    .pm_i    (pm_i),
    .prod_i  (prod_q),
    .scaled_o(scaled)
  );

  assign op_fire = op_valid_i & op_known;

  always_comb begin
    prod_d = prod_q;
    if (op_fire) prod_d = mul_res;
    if (hi_load_i) prod_d[PROD_W-1:DATA_W] = hi_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmp_q  <= '0;
      prod_q <= '0;
      acc_q  <= ACC_NONE;
    end else begin
      if (tmp_we_i) tmp_q <= data_i;
      prod_q <= prod_d;
      acc_q  <= op_fire ? op_acc : ACC_NONE;
    end
  end

  assign prod_hi_o = scaled[PROD_W-1:DATA_W];
  assign prod_lo_o = scaled[DATA_W-1:0];
  assign acc_cmd_o = acc_q;

  // R6: idle or unknown mode without a high load keeps the product
  assert_prod_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(op_valid_i && op_known) && !hi_load_i) |=> $stable(prod_q));

  // R9: high load alone touches only the upper half
  assert_hi_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_load_i && !op_valid_i) |=>
      (prod_q[DATA_W-1:0] == $past(prod_q[DATA_W-1:0])) &&
      (prod_q[PROD_W-1:DATA_W] == $past(hi_data_i)));

  // R5: multiply by immediate zero clears
  assert_imm_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_mode_i == MODE_MUL_IMM && imm_i == '0 && !hi_load_i)
      |=> prod_q == '0);

  // R4: a square is never negative
  assert_square_pos_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_mode_i == MODE_SQR_ADD || op_mode_i == MODE_SQR_SUB)
      && !hi_load_i) |=> !prod_q[PROD_W-1]);

  // R4: subtract directive follows a square-subtract strobe
  assert_acc_sub_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_mode_i == MODE_SQR_SUB) |=> acc_cmd_o == ACC_SUB);

  // R7: right-shift readout replicates the sign into the top bits
  assert_shr_sign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_i == PM_SHR_C) |->
      prod_hi_o[DATA_W-1 -: SHR_C+1] == {(SHR_C+1){prod_q[PROD_W-1]}});
endmodule

// File: tb/prod_mul_unit_tb.sv
module prod_mul_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmp_we = 1'b0, op_valid = 1'b0, hi_load = 1'b0;
  logic [2:0]  op_mode = 3'b000;
  logic [15:0] data = '0, imm = '0, hi_data = '0;
  logic [1:0]  pm = 2'b00;
  logic [15:0] prod_hi, prod_lo;
  logic [1:0]  acc_cmd;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  prod_mul_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tmp_we_i(tmp_we), .op_valid_i(op_valid),
    .op_mode_i(op_mode), .data_i(data), .imm_i(imm), .hi_load_i(hi_load),
    .hi_data_i(hi_data), .pm_i(pm), .prod_hi_o(prod_hi), .prod_lo_o(prod_lo),
    .acc_cmd_o(acc_cmd)
  );

  // tmp, data, mode, imm, expected product, expected acc_cmd
  localparam int NV = 10;
  localparam logic [84:0] VEC [NV] = '{
    {16'h0003, 16'h0005, 3'b000, 16'h0000, 32'h0000000F, 2'b00},
    {16'hFFFF, 16'h0002, 3'b000, 16'h0000, 32'hFFFFFFFE, 2'b00},
    {16'h8000, 16'h8000, 3'b000, 16'h0000, 32'h40000000, 2'b00},
    {16'h7FFF, 16'h8000, 3'b000, 16'h0000, 32'hC0008000, 2'b00},
    {16'hFFFF, 16'hFFFF, 3'b001, 16'h0000, 32'hFFFE0001, 2'b00},
    {16'h8000, 16'h0002, 3'b001, 16'h0000, 32'h00010000, 2'b00},
    {16'h1234, 16'hFFFD, 3'b010, 16'h0000, 32'h00000009, 2'b01},
    {16'h1234, 16'h0100, 3'b011, 16'h0000, 32'h00010000, 2'b10},
    {16'h0010, 16'h0000, 3'b100, 16'hFFFF, 32'hFFFFFFF0, 2'b00},
    {16'h7FFF, 16'h0000, 3'b100, 16'h0002, 32'h0000FFFE, 2'b00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then release; result visible at return
  task automatic cycle(input logic we, input logic [15:0] d, input logic v,
                       input logic [2:0] m, input logic [15:0] im,
                       input logic hl, input logic [15:0] hd);
    @(negedge clk);
    tmp_we = we; data = d; op_valid = v; op_mode = m; imm = im;
    hi_load = hl; hi_data = hd;
    @(negedge clk);
    tmp_we = 1'b0; op_valid = 1'b0; hi_load = 1'b0;
  endtask

  function automatic logic [31:0] rd();
    return {prod_hi, prod_lo};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 product", rd(), 32'h0);
    check("R1 acc_cmd", {30'b0, acc_cmd}, 32'h0);
    // R1: temporary register resets to zero -> signed multiply gives 0
    cycle(1'b0, 16'h7777, 1'b1, 3'b000, 16'h0, 1'b0, 16'h0);
    check("R1 tmp zero", rd(), 32'h0);

    // R2 R3 R4 R5: vector table
    for (int i = 0; i < NV; i++) begin
      cycle(1'b1, VEC[i][84:69], 1'b0, 3'b000, 16'h0, 1'b0, 16'h0);
      cycle(1'b0, VEC[i][68:53], 1'b1, VEC[i][52:50], VEC[i][49:34], 1'b0, 16'h0);
      check($sformatf("R2-5 vec%0d product", i), rd(), VEC[i][33:2]);
      check($sformatf("R4 vec%0d acc_cmd", i), {30'b0, acc_cmd}, {30'b0, VEC[i][1:0]});
    end
    @(negedge clk);
    check("R4 acc_cmd pulse ends", {30'b0, acc_cmd}, 32'h0);

    // R12: restore 0x92345678
    cycle(1'b1, 16'h5678, 1'b0, 3'b000, 16'h0, 1'b0, 16'h0);
    cycle(1'b0, 16'h0, 1'b1, 3'b100, 16'h0001, 1'b0, 16'h0);
    cycle(1'b0, 16'h0, 1'b0, 3'b000, 16'h0, 1'b1, 16'h9234);
    check("R12 restore", rd(), 32'h92345678);

    // R7 R8: scaling modes, both halves
    pm = 2'b01; #1;
    check("R7 R8 shl1", rd(), 32'h2468ACF0);
    pm = 2'b10; #1;
    check("R7 R8 shl4", rd(), 32'h23456780);
    pm = 2'b11; #1;
    check("R7 R8 shr6", rd(), 32'hFE48D159);
    pm = 2'b00; #1;

    // R6: undefined modes
    for (int m = 5; m < 8; m++) begin
      cycle(1'b0, 16'h0003, 1'b1, 3'(m), 16'h0005, 1'b0, 16'h0);
      check($sformatf("R6 mode %0d product", m), rd(), 32'h92345678);
      check($sformatf("R6 mode %0d acc_cmd", m), {30'b0, acc_cmd}, 32'h0);
    end

    // R5: multiply by immediate zero clears
    cycle(1'b0, 16'h0, 1'b1, 3'b100, 16'h0000, 1'b0, 16'h0);
    check("R5 clear", rd(), 32'h0);

    // R9: high load alone
    cycle(1'b1, 16'h0003, 1'b0, 3'b000, 16'h0, 1'b0, 16'h0);
    cycle(1'b0, 16'h0005, 1'b1, 3'b000, 16'h0, 1'b0, 16'h0);
    cycle(1'b0, 16'h0, 1'b0, 3'b000, 16'h0, 1'b1, 16'hABCD);
    check("R9 hi load", rd(), 32'hABCD000F);

    // R10: multiply and high load together
    cycle(1'b1, 16'h0002, 1'b0, 3'b000, 16'h0, 1'b0, 16'h0);
    cycle(1'b0, 16'hFFFF, 1'b1, 3'b000, 16'h0, 1'b1, 16'h1357);
    check("R10 merge", rd(), 32'h1357FFFE);

    // R11: tmp write during multiply uses old tmp
    cycle(1'b1, 16'h0003, 1'b1, 3'b000, 16'h0, 1'b0, 16'h0);
    check("R11 old tmp", rd(), 32'h00000006);
    cycle(1'b0, 16'h0100, 1'b1, 3'b000, 16'h0, 1'b0, 16'h0);
    check("R11 new tmp", rd(), 32'h00000300);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule